// File: doc/BRIEF.md
# Low-Power Real-Time Counter

This block keeps time as a 47-bit binary fixed-point number: the upper 32 bits count whole seconds and the lower 15 bits count fractions of a second. It advances once per edge of a slow 32.768 kHz clock that belongs to a battery-backed domain with its own reset. Software reaches the block through a small 32-bit register bus that runs on the faster processor clock. The bus has a control register, which holds the run bit and a calibration setting, and two read/write windows onto the count.

Every crossing between the two domains is deliberate. The run request passes through a two-flop synchroniser. The run bit that software reads back is the slow domain's real state, brought back through a second synchroniser, so software polls it until it matches what was written. A load is staged on the processor side and handed over with a toggle request/acknowledge handshake. Counter reads sample the live slow-domain count with no holding register. Software therefore reads the high and low words twice and repeats until both pairs agree.

Top module: `lp_rtc`

## Requirements
- R1: After both resets, the control register, the high count word and the low count word all read 0.
- R2: A read at byte address 0x50 returns count bits 46:32 in data bits 14:0, with bits 31:15 zero. A read at 0x54 returns count bits 31:0.
- R3: While the slow domain is stopped, the count keeps its value.
- R4: While the slow domain is running with calibration off, the count grows by exactly one on every slow-clock rising edge, carrying from the low word into the high word.
- R5: Bit 0 of the control register (address 0x38) reads back the slow domain's actual run state. After a write that changes it, bit 0 first keeps returning the old value and returns the new value only once the slow domain has switched.
- R6: At the first read in which bit 0 returns 1 after a start, the count still equals its previous value. From then on it advances by one per slow edge, so the first increment lands two slow cycles after the request.
- R7: Writing the high word at 0x50 and then the low word at 0x54 while stopped loads the count with that value. The write to the low word commits the load.
- R8: Writes to 0x50 or 0x54 have no effect while the run bit is written as 1 or still reads back as 1. An ignored high-word write leaves the staged high word unchanged, so a later load that writes only the low word keeps the earlier high word.
- R9: In the control register, bit 8 (calibration on) and bits 14:10 (calibration value) read back as written. All other bits except bit 0 read 0.
- R10: With calibration on, the 5-bit calibration value is taken as a signed number v. The step counter restarts at every load and counts only running steps. Every CAL_PERIOD-th running step adds 1+v instead of 1.
- R11: A read at any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor bus clock |
| rst_n | input | 1 | Active-low reset of the processor-side registers |
| slow_clk | input | 1 | 32.768 kHz counting clock |
| slow_rst_n | input | 1 | Active-low reset of the retained slow domain |
| addr | input | 8 | Byte address of the register access |
| wr_en | input | 1 | Write strobe, sampled on the rising edge of clk |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for addr |

## Verification
The assertions check on every slow edge that a stopped count holds and that a running count outside a calibration step grows by exactly one. They also check that the calibrated step adds 1+v, that the staged load words cannot change while the counter is running, and that the high word's unused bits read zero. Some behaviours span both clocks and only the bench's scenarios show them. These are the delayed readback of the run bit, the count being unchanged at the moment the run bit first reads 1, the load handshake, torn-read recovery across a low-to-high carry, and calibration with both negative and positive values. The bench checks each of these against a behavioural model that steps on the slow clock.

// File: rtl/lp_rtc.sv
module lp_rtc #(
  parameter int CAL_PERIOD = 32768,
  parameter int CAL_W      = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slow_clk,
  input  logic        slow_rst_n,
  input  logic [7:0]  addr,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data
);
  localparam int CW   = 47;
  localparam int HI_W = CW - 32;
  localparam int EW   = $clog2(CAL_PERIOD);
  localparam logic [7:0] A_CTL = 8'h38;
  localparam logic [7:0] A_HI  = 8'h50;
  localparam logic [7:0] A_LO  = 8'h54;
  localparam logic [EW-1:0] E_LAST = EW'(CAL_PERIOD - 1);

  // processor domain
  logic             en_req, cal_en, ld_tog;
  logic [CAL_W-1:0] cal_val;
  logic [HI_W-1:0]  ld_hi;
  logic [31:0]      ld_lo;
  logic             ack_m1, ack_m2, run_m1, run_m2;

  // slow domain
  logic             en_m1, run, tog_m1, tog_m2, tog_seen, cal_m1, cal_on;
  logic [CW-1:0]    count, step;
  logic [EW-1:0]    epoch;

  wire locked   = en_req | run_m2 | (ack_m2 != ld_tog);
  wire load_now = tog_m2 != tog_seen;
  wire boundary = epoch == E_LAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_req <= 1'b0; cal_en <= 1'b0; cal_val <= '0;
      ld_hi <= '0; ld_lo <= '0; ld_tog <= 1'b0;
      ack_m1 <= 1'b0; ack_m2 <= 1'b0; run_m1 <= 1'b0; run_m2 <= 1'b0;
    end else begin
      ack_m1 <= tog_seen; ack_m2 <= ack_m1;
      run_m1 <= run;      run_m2 <= run_m1;
      if (wr_en && addr == A_CTL) begin
        en_req  <= wr_data[0];
        cal_en  <= wr_data[8];
        cal_val <= wr_data[10 +: CAL_W];
      end
      if (wr_en && addr == A_HI && !locked) ld_hi <= wr_data[HI_W-1:0];
      if (wr_en && addr == A_LO && !locked) begin
        ld_lo  <= wr_data;
        ld_tog <= ~ld_tog;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      A_CTL: begin
        rd_data[0]            = run_m2;
        rd_data[8]            = cal_en;
        rd_data[10 +: CAL_W]  = cal_val;
      end
      A_HI:    rd_data[HI_W-1:0] = count[CW-1:32];
      A_LO:    rd_data = count[31:0];
      default: rd_data = '0;
    endcase
  end

  assign step = (cal_on && boundary)
              ? CW'(1) + {{(CW-CAL_W){cal_val[CAL_W-1]}}, cal_val}
              : CW'(1);

  always_ff @(posedge slow_clk or negedge slow_rst_n) begin
    if (!slow_rst_n) begin
      en_m1 <= 1'b0; run <= 1'b0;
      tog_m1 <= 1'b0; tog_m2 <= 1'b0; tog_seen <= 1'b0;
      cal_m1 <= 1'b0; cal_on <= 1'b0;
      count <= '0; epoch <= '0;
    end else begin
      en_m1  <= en_req; run <= en_m1;
      tog_m1 <= ld_tog; tog_m2 <= tog_m1;
      cal_m1 <= cal_en; cal_on <= cal_m1;
      if (load_now) begin
        count    <= {ld_hi, ld_lo};
        epoch    <= '0;
        tog_seen <= tog_m2;
      end else if (run) begin
        count <= count + step;
        epoch <= boundary ? '0 : epoch + 1'b1;
      end
    end
  end

  a_r3_hold_when_stopped: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
    (!run && !load_now) |=> $stable(count));

  a_r4_unit_step: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
    (run && !load_now && !boundary) |=> (count == $past(count) + CW'(1)));

  a_r10_cal_step: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
    (run && !load_now && boundary && cal_on && $stable(cal_val)) |=>
      (count == $past(count) + CW'(1) + {{(CW-CAL_W){cal_val[CAL_W-1]}}, cal_val}));

  a_r8_stage_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == A_LO || addr == A_HI) && (en_req || run_m2)) |=>
      ($stable(ld_lo) && $stable(ld_hi) && $stable(ld_tog)));

  a_r2_hi_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_HI) |-> (rd_data[31:HI_W] == '0));
endmodule

// File: tb/lp_rtc_bench.sv
`timescale 1ns/1ps
module lp_rtc_bench;
  localparam int P = 16;
  logic clk = 1'b0, slow_clk = 1'b0, rst_n = 1'b0, slow_rst_n = 1'b0;
  logic [7:0] addr = 8'h00;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0, rd_data;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  // behavioural model
  longint m_ref = 0;
  int     m_epoch = 0;
  bit     m_run = 1'b0, m_cal = 1'b0;
  int     m_v = 0;

  lp_rtc #(.CAL_PERIOD(P)) u_lp_rtc (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .slow_rst_n(slow_rst_n),
    .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data));

  always #4 clk = ~clk;
  initial begin #2; forever #64 slow_clk = ~slow_clk; end

  always @(posedge slow_clk) if (m_run) begin
    if (m_cal && m_epoch == P-1) m_ref = m_ref + 1 + m_v;
    else m_ref = m_ref + 1;
    m_epoch = (m_epoch == P-1) ? 0 : m_epoch + 1;
    m_ref = m_ref & ((64'd1 << 47) - 1);
  end

  task automatic chk(input string tag, input longint got, input longint exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rd_data;
  endtask

  task automatic rd_count(output longint c);
    logic [31:0] h1, l1, h2, l2;
    for (int k = 0; k < 8; k++) begin
      rd(8'h50, h1); rd(8'h54, l1); rd(8'h50, h2); rd(8'h54, l2);
      if (h1 == h2 && l1 == l2) break;
    end
    c = {17'd0, h1[14:0], l1};
  endtask

  task automatic poll_run(input bit want, output bit saw_old, output int n);
    logic [31:0] d;
    saw_old = 1'b0; n = 0;
    for (int k = 0; k < 200; k++) begin
      rd(8'h38, d);
      n++;
      if (d[0] == want) break;
      saw_old = 1'b1;
    end
    m_run = want;
  endtask

  task automatic load(input logic [14:0] hi, input logic [31:0] lo, input bit write_hi);
    if (write_hi) wr(8'h50, {17'd0, hi});
    wr(8'h54, lo);
    repeat (5) @(posedge slow_clk);
    m_ref = {17'd0, hi, lo}; m_epoch = 0;
  endtask

  initial begin
    logic [31:0] d;
    longint c;
    bit saw;
    int n;
    repeat (5) @(negedge clk);
    rst_n = 1'b1; slow_rst_n = 1'b1;
    repeat (2) @(negedge clk);

    rd(8'h38, d); chk("R1 ctrl after reset", d, 0);
    rd(8'h50, d); chk("R1 high after reset", d, 0);
    rd(8'h54, d); chk("R1 low after reset", d, 0);

    wr(8'h38, 32'hFFFF_FFFE);
    rd(8'h38, d); chk("R9 ctrl field readback", d, 32'h0000_7D00);
    wr(8'h38, 32'h0);
    rd(8'h40, d); chk("R11 unmapped read", d, 0);

    load(15'h1234, 32'hFFFF_FFF0, 1'b1);
    rd_count(c); chk("R7 loaded count", c, m_ref);
    repeat (5) @(posedge slow_clk);
    rd_count(c); chk("R3 holds while stopped", c, m_ref);

    wr(8'h38, 32'h1);
    poll_run(1'b1, saw, n);
    chk("R5 start reads old state first", saw, 1);
    rd_count(c); chk("R6 count unchanged at first run readback", c, m_ref);
    repeat (3) @(posedge slow_clk);
    rd_count(c); chk("R6 three steps after start", c, {17'd0, 15'h1234, 32'hFFFF_FFF3});
    repeat (40) @(posedge slow_clk);
    rd_count(c); chk("R4 carry into high word", c, m_ref);
    rd(8'h50, d); chk("R2 high word bits", d, 32'h0000_1235);

    wr(8'h50, 32'h0000_7FFF);
    wr(8'h54, 32'h0);
    repeat (6) @(posedge slow_clk);
    rd_count(c); chk("R8 writes ignored while running", c, m_ref);

    wr(8'h38, 32'h0);
    poll_run(1'b0, saw, n);
    chk("R5 stop reads old state first", saw, 1);
    rd_count(c); c = c; 
    repeat (5) @(posedge slow_clk);
    rd_count(c); chk("R3 holds after stop", c, m_ref);

    load(15'h0, 32'h0000_0100, 1'b0);
    rd(8'h50, d); chk("R8 staged high word kept", d, 32'h0000_1234);
    rd(8'h54, d); chk("R7 low-only load", d, 32'h0000_0100);

    // calibration, v = -3
    wr(8'h38, 32'h0000_7500);
    m_cal = 1'b1; m_v = -3;
    rd(8'h38, d); chk("R9 cal fields", d, 32'h0000_7500);
    load(15'h0, 32'h0000_1000, 1'b1);
    wr(8'h38, 32'h0000_7501);
    poll_run(1'b1, saw, n);
    repeat (50) @(posedge slow_clk);
    rd_count(c); chk("R10 negative calibration", c, m_ref);
    chk("R10 negative calibration abs", c, 64'h1000 + 50 - 3*3);

    // v = +5 while running
    wr(8'h38, 32'h0000_1501);
    m_v = 5;
    repeat (40) @(posedge slow_clk);
    rd_count(c); chk("R10 positive calibration", c, m_ref);
    rd(8'h38, d); chk("R9 ctrl while running", d, 32'h0000_1501);

    wr(8'h38, 32'h0000_1500);
    poll_run(1'b0, saw, n);
    repeat (3) @(posedge slow_clk);
    rd_count(c); chk("R3 final hold", c, m_ref);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule